// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

Two identical 32-bit down-counting timers are reached through one word-addressed register port. Each timer counts down once for every cycle in which the shared tick-enable input is high. It can run periodically or as a one-shot. When it expires it sets a sticky status flag, and it drives its own interrupt line, which is that flag gated by an enable bit.

Software programs a reload value, starts the timer through its control word, and clears the status flag by writing a one to it. A separate background-reload register changes the reload value for the next period without disturbing the count that is in progress. The register port is plain and synchronous. A write takes effect on the clock edge that samples `wr_en_i`. Read data is combinational from `addr_i` and shows the state the registers hold after the last edge. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `twin_timer`

## Requirements
- R1: Each timer owns six word registers at local offsets 0 (count, read-only), 1 (reload), 2 (background reload), 3 (control), 4 (raw status) and 5 (masked status, read-only). Timer k sits at word base 6*k. Words at addresses 12 and above read as zero, and writes to them change nothing.
- R2: After reset every register of both timers reads zero, and both interrupt outputs are low.
- R3: Control bit 0 is enable, bit 1 is one-shot and bit 2 is interrupt enable; the control word reads back as written in bits 2:0. A control write with bit 0 set loads the count from the reload register. A control write with bit 0 clear stops the count where it is.
- R4: While the timer is enabled and its count is nonzero, the count drops by one on every cycle in which tick_i is high. It holds when tick_i is low or the timer is disabled.
- R5: Expiry sets raw status bit 0, which stays set until software clears it. Expiry is a tick that takes the count from 1 to 0, or a load of 0 into an enabled timer.
- R6: Writing raw status with bit 0 at 1 clears the flag, and writing 0 leaves it unchanged. If an expiry falls in the same cycle as a clear, the flag ends set.
- R7: Masked status bit 0 and that timer's irq_o bit both equal raw status AND control bit 2.
- R8: Writes to the count and masked-status offsets have no effect.
- R9: A reload write to an enabled timer loads the count at once and restarts it. To a disabled timer it only stores the value.
- R10: A background-reload write stores the value in both the background and the reload registers and leaves the running count untouched.
- R11: In periodic mode (control bit 1 = 0), a tick expiry loads the count from the reload register and counting continues.
- R12: In one-shot mode (control bit 1 = 1) the count stays at 0 after expiry while further ticks arrive.
- R13: The two timers are independent. Activity on one leaves the other's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count pacing strobe shared by both timers |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Interrupt per timer, bit k for timer k |

## Verification
Every register write and every tick lands on the clock edge that samples it. The changed count, status and interrupt are therefore visible one edge after the stimulus, and nothing takes longer. The bench drives each input at a falling edge and holds it across exactly one rising edge per intended cycle. It then reads the combinational read port at the next falling edge, where all results of that edge have settled. Tick windows are counted in whole rising edges, so a window of n ticks must show the count lower by exactly n, or reloaded where an expiry fell inside the window.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int REGS_PER_TIMER = 6;
  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_COUNT  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_RELOAD = 3'd1;
  localparam logic [OFF_W-1:0] OFF_BGLOAD = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_RAW    = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MASKED = 3'd5;

  typedef struct packed {
    logic irq_en;
    logic one_shot;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/twin_timer_decode.sv
module twin_timer_decode
  import twin_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic                               wr_en_i,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0]  words_i,
  output logic [NUM_TIMERS-1:0]              wr_o,
  output logic [NUM_TIMERS-1:0][OFF_W-1:0]   off_o,
  output logic [DATA_W-1:0]                  rdata_o
);
  logic [NUM_TIMERS-1:0] hit;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_win
    localparam int BASE = i * REGS_PER_TIMER;
    assign hit[i] = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + REGS_PER_TIMER);
    assign off_o[i] = OFF_W'(addr_i - ADDR_W'(BASE));
    assign wr_o[i]  = wr_en_i && hit[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (hit[i]) rdata_o = words_i[i];
    end
  end

  always_comb begin
    assert ($onehot0(wr_o)) else $error("AST_ONE_WINDOW"); // R1
  end
endmodule

// File: rtl/twin_timer_unit.sv
module twin_timer_unit
  import twin_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] count_q, reload_q, bgload_q;
  ctrl_t             ctrl_q;
  logic              raw_q;

  logic wr_ctrl, wr_reload, wr_bg, wr_raw;
  logic run, step, tick_exp, load_exp, clear_req;

  assign wr_ctrl   = wr_i && (off_i == OFF_CTRL);
  assign wr_reload = wr_i && (off_i == OFF_RELOAD);
  assign wr_bg     = wr_i && (off_i == OFF_BGLOAD);
  assign wr_raw    = wr_i && (off_i == OFF_RAW);

  // A count step happens only if no write overrides the counter this cycle
  assign run       = ctrl_q.enable && tick_i && (count_q != '0);
  assign step      = run && !wr_ctrl && !(wr_reload && ctrl_q.enable);
  assign tick_exp  = step && (count_q == DATA_W'(1));
  assign load_exp  = (wr_ctrl && wdata_i[0] && (reload_q == '0)) ||
                     (wr_reload && ctrl_q.enable && (wdata_i == '0));
  assign clear_req = wr_raw && wdata_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      bgload_q <= '0;
      ctrl_q   <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_t'(wdata_i[2:0]);
        if (wdata_i[0]) count_q <= reload_q;
      end else if (wr_reload && ctrl_q.enable) begin
        count_q <= wdata_i;
      end else if (step) begin
        if (tick_exp) count_q <= ctrl_q.one_shot ? '0 : reload_q;
        else          count_q <= count_q - DATA_W'(1);
      end

      if (wr_reload) reload_q <= wdata_i;
      if (wr_bg) begin
        bgload_q <= wdata_i;
        reload_q <= wdata_i;
      end

      if (tick_exp || load_exp) raw_q <= 1'b1;
      else if (clear_req)       raw_q <= 1'b0;
    end
  end

  assign irq_o = raw_q && ctrl_q.irq_en;

  always_comb begin
    unique case (off_i)
      OFF_COUNT:  word_o = count_q;
      OFF_RELOAD: word_o = reload_q;
      OFF_BGLOAD: word_o = bgload_q;
      OFF_CTRL:   word_o = DATA_W'(ctrl_q);
      OFF_RAW:    word_o = DATA_W'(raw_q);
      OFF_MASKED: word_o = DATA_W'(irq_o);
      default:    word_o = '0;
    endcase
  end

  AST_STICKY_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q && !clear_req |=> raw_q); // R5
  AST_CLEAR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req && !tick_exp && !load_exp |=> !raw_q); // R6
  AST_RO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && (off_i == OFF_COUNT) && !tick_i |=> $stable(count_q)); // R8
  AST_BG_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bg && !tick_i |=> $stable(count_q)); // R10
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.one_shot && (count_q == '0) && !wr_i |=> (count_q == '0)); // R12
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_i |=> $stable(count_q)); // R4
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_TIMERS-1:0] irq_o
);
  logic [NUM_TIMERS-1:0]             wr;
  logic [NUM_TIMERS-1:0][OFF_W-1:0]  off;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] words;

  twin_timer_decode #(
    .NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) decode_i (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .words_i(words),
    .wr_o(wr), .off_o(off), .rdata_o(rdata_o)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    twin_timer_unit #(.DATA_W(DATA_W)) unit_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .wr_i(wr[i]), .off_i(off[i]), .wdata_i(wdata_i),
      .word_o(words[i]), .irq_o(irq_o[i])
    );
  end

  AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0)); // R2
endmodule

// File: tb/twin_timer_tb.sv
module twin_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  twin_timer dut_i (.*);

  // {is_read, addr, data}: write data, or expected read value
  localparam logic [36:0] VEC [16] = '{
    {1'b0, 4'd1,  32'd5},   // R9 reload write while disabled
    {1'b1, 4'd1,  32'd5},   // R1
    {1'b1, 4'd0,  32'd0},   // R9 count untouched
    {1'b0, 4'd3,  32'd1},   // R3 enable
    {1'b1, 4'd0,  32'd5},   // R3 count loaded
    {1'b1, 4'd3,  32'd1},   // R3
    {1'b0, 4'd0,  32'd77},  // R8
    {1'b1, 4'd0,  32'd5},   // R8
    {1'b0, 4'd8,  32'd9},   // R10 timer 1 background reload
    {1'b1, 4'd7,  32'd9},   // R10
    {1'b1, 4'd8,  32'd9},   // R10
    {1'b1, 4'd6,  32'd0},   // R10 no restart
    {1'b0, 4'd12, 32'd1},   // R1 outside window
    {1'b1, 4'd12, 32'd0},   // R1
    {1'b1, 4'd15, 32'd0},   // R1
    {1'b1, 4'd5,  32'd0}    // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; tick_i = tk;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    for (int a = 0; a < 12; a++) rd("R2", 4'(a), 32'd0);
    chk("R2 irq", 32'(irq_o), 32'd0);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][36]) rd("R1/table", VEC[i][35:32], VEC[i][31:0]);
      else            wr(VEC[i][35:32], VEC[i][31:0]);
    end

    // timer 0: enabled periodic, count 5, reload 5
    ticks(4);
    rd("R4 decrement", 4'd0, 32'd1);
    repeat (2) @(negedge clk);
    rd("R4 hold without tick", 4'd0, 32'd1);
    ticks(1);
    rd("R11 periodic reload", 4'd0, 32'd5);
    rd("R5 raw set", 4'd4, 32'd1);
    rd("R7 masked off", 4'd5, 32'd0);
    chk("R7 irq off", 32'(irq_o), 32'd0);
    wr(4'd3, 32'd5);
    rd("R7 masked on", 4'd5, 32'd1);
    chk("R7 irq on", 32'(irq_o), 32'd1);
    chk("R13 irq1 quiet", 32'(irq_o[1]), 32'd0);
    wr(4'd4, 32'd0);
    rd("R6 write zero keeps", 4'd4, 32'd1);
    wr(4'd4, 32'd1);
    rd("R6 clear", 4'd4, 32'd0);
    chk("R7 irq cleared", 32'(irq_o), 32'd0);

    // one-shot
    wr(4'd1, 32'd2);
    rd("R9 reload restarts", 4'd0, 32'd2);
    wr(4'd3, 32'd3);
    ticks(2);
    rd("R12 reaches zero", 4'd0, 32'd0);
    rd("R5 one-shot expiry", 4'd4, 32'd1);
    ticks(3);
    rd("R12 stays zero", 4'd0, 32'd0);
    wr(4'd4, 32'd1);
    wr(4'd1, 32'd0);
    rd("R5 load zero expiry", 4'd4, 32'd1);
    wr(4'd4, 32'd1);

    // disabled reload store
    wr(4'd3, 32'd0);
    rd("R3 stop", 4'd3, 32'd0);
    wr(4'd1, 32'd7);
    rd("R9 disabled store only", 4'd0, 32'd0);
    rd("R9 reload stored", 4'd1, 32'd7);

    // background reload keeps count
    wr(4'd3, 32'd1);
    ticks(2);
    rd("R4 count", 4'd0, 32'd5);
    wr(4'd2, 32'd3);
    rd("R10 count kept", 4'd0, 32'd5);
    rd("R10 reload updated", 4'd1, 32'd3);
    ticks(5);
    rd("R11 reload from background", 4'd0, 32'd3);
    rd("R5 raw", 4'd4, 32'd1);

    // expiry and clear in the same cycle
    ticks(2);
    rd("R4 at one", 4'd0, 32'd1);
    wr(4'd4, 32'd1, 1'b1);
    rd("R6 set wins", 4'd4, 32'd1);
    rd("R11 reload", 4'd0, 32'd3);

    // timer 1 untouched
    rd("R13 t1 count", 4'd6, 32'd0);
    rd("R13 t1 raw", 4'd10, 32'd0);
    rd("R13 t1 ctrl", 4'd9, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule